// File: doc/BRIEF.md
# I2C Target Register Pointer with Auto-Increment

This block sits between the bit-level shifter of a small I2C target device and its register file. The shifter hands it decoded bus events: a START pulse, a STOP pulse, a received-byte strobe with its byte, and a request for the next byte to transmit. The block compares the address byte with a fixed four-bit prefix and three strap bits, and returns the acknowledge decision. In a write transfer it keeps the first data byte as a control byte. Any later bytes go out as write strobes to a ten-entry register file.

The control byte holds a four-bit register pointer and an auto-increment flag. When the flag is set, the pointer steps forward after every register access and wraps back to zero after the last implemented register. In a read transfer the block issues read strobes at the pointer and returns the byte to send. The register file must answer a read combinationally, in the same cycle. An auto-increment read that begins at pointer zero is refused: the block sends FFh and raises an error flag that holds until STOP.

Top module: `i2c_reg_pointer`

## Requirements
- R1: After reset the control byte is 00h. All strobes (ack_valid, wr_en, rd_en, tx_valid) and ai_err are low.
- R2: An address byte whose bits 7:4 are 1100 and whose bits 3:1 equal addr_sel is acknowledged. ack_valid and ack are high for one cycle, beginning one cycle after rx_valid. A byte received in the control or data phase is also acknowledged (ack=1).
- R3: Bit 0 of a matching address byte sets the direction. A 1 starts a read transfer and a 0 starts a write transfer.
- R4: In a write transfer, the first byte after the address is stored as the control byte. Bit 4 is the auto-increment flag and bits 3:0 are the pointer. Bits 7:5 are stored as zero whatever is written to them.
- R5: Each later byte in the same write transfer produces a one-cycle wr_en, starting one cycle after rx_valid. The strobe carries wr_idx equal to the pointer and wr_data equal to the byte.
- R6: With the flag set, the pointer advances by one after each register write or read. With the flag clear, it does not move.
- R7: On advance, a pointer at 9 or above (the last register and the unimplemented ones) returns to 0.
- R8: Pointer values 10 to 15 produce no wr_en and no rd_en. A read at those values transmits 00h. The pointer still advances when the flag is set.
- R9: If the first read of a read transfer finds the flag set and the pointer at 0, the block does three things. It transmits FFh, it sets ai_err, and it leaves the pointer unchanged. ai_err stays set until the cycle after a STOP.
- R10: An address byte that does not match gets ack_valid with ack=0. After that, no byte causes ack_valid, wr_en or rd_en until the next START.
- R11: A STOP or a repeated START ends the transfer but keeps the control byte, including the pointer value it has reached.
- R12: A tx_req in a read transfer raises rd_en (with rd_idx) one cycle later, and raises tx_valid with tx_byte two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 3 | Strap bits compared with address bits 3:1 |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | A byte from the controller is complete |
| rx_byte | input | 8 | Byte received from the controller |
| tx_req | input | 1 | Shifter asks for the next byte to send |
| rf_rdata | input | 8 | Register file data at rd_idx, combinational |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register index for the write |
| wr_data | output | 8 | Write data |
| rd_en | output | 1 | Register read strobe |
| rd_idx | output | 4 | Register index for the read |
| tx_valid | output | 1 | tx_byte is valid |
| tx_byte | output | 8 | Byte to transmit |
| ai_err | output | 1 | Sticky: auto-increment read began at pointer 0 |

## Verification
Every output is registered, so the results arrive at fixed times. The acknowledge decision and the write strobe come one cycle after the received-byte strobe. The read strobe comes one cycle after tx_req, and the transmit byte one cycle after the read strobe. The error flag changes in the same cycle as the read strobe would. The bench drives inputs on the falling edge and runs its reference model on the rising edge, where it applies exactly these delays. It compares every output with the model on the next falling edge, in every cycle, so a result one cycle early or late is reported at once.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  localparam int PTR_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int AI_BIT     = 4;
  localparam logic [3:0] ADDR_PREFIX = 4'b1100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } xfer_st_t;

  typedef enum logic [1:0] {
    RK_REG,
    RK_ZERO,
    RK_ERR
  } rd_kind_t;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] cur,
                                                input logic [PTR_W-1:0] last);
    if (cur >= last) return '0;
    return cur + 1'b1;
  endfunction

endpackage

// File: rtl/i2c_ptr_addr_chk.sv
module i2c_ptr_addr_chk
  import i2c_ptr_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [SEL_W-1:0]  addr_sel,
  output logic              match,
  output logic              is_read
);
  localparam int PFX_W = BYTE_W - 1 - SEL_W;

  logic pfx_ok;
  logic sel_ok;

  always_comb begin
    pfx_ok  = (addr_byte[BYTE_W-1 -: PFX_W] == ADDR_PREFIX[PFX_W-1:0]);
    sel_ok  = (addr_byte[SEL_W:1] == addr_sel);
    match   = pfx_ok && sel_ok;
    is_read = addr_byte[0];
  end
endmodule

// File: rtl/i2c_ptr_ctrl.sv
module i2c_ptr_ctrl
  import i2c_ptr_pkg::*;
#(
  parameter int NUM_REGS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              adv,
  output logic              ai,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);
  localparam int UNUSED_W = BYTE_W - AI_BIT - 1;

  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (load) begin
      ctrl_q <= {{UNUSED_W{1'b0}}, load_byte[AI_BIT:0]};
    end else if (adv && ctrl_q[AI_BIT]) begin
      ctrl_q[PTR_W-1:0] <= ptr_next(ctrl_q[PTR_W-1:0], LAST_IDX);
    end
  end

  assign ai  = ctrl_q[AI_BIT];
  assign ptr = ctrl_q[PTR_W-1:0];

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[BYTE_W-1:AI_BIT+1] == '0); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ai && (ptr >= LAST_IDX)) |=> (ptr == '0)); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !(adv && ai)) |=> $stable(ctrl_q)); // R6
endmodule

// File: rtl/i2c_ptr_rdpath.sv
module i2c_ptr_rdpath
  import i2c_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  rd_kind_t          issue_kind,
  input  logic [PTR_W-1:0]  issue_idx,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              rd_en,
  output logic [PTR_W-1:0]  rd_idx,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  logic     s1_v;
  rd_kind_t s1_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_kind <= RK_REG;
      rd_en   <= 1'b0;
      rd_idx  <= '0;
    end else begin
      s1_v    <= issue;
      s1_kind <= issue_kind;
      rd_en   <= issue && (issue_kind == RK_REG);
      if (issue) rd_idx <= issue_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= s1_v;
      if (s1_v) begin
        unique case (s1_kind)
          RK_REG:  tx_byte <= rf_rdata;
          RK_ZERO: tx_byte <= '0;
          default: tx_byte <= '1;
        endcase
      end
    end
  end

  AST_TX_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> tx_valid); // R12
endmodule

// File: rtl/i2c_reg_pointer.sv
module i2c_reg_pointer
  import i2c_ptr_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_req,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              ack_valid,
  output logic              ack,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en,
  output logic [PTR_W-1:0]  rd_idx,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ai_err
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  xfer_st_t state, state_n;
  logic     addr_match, addr_rd;
  logic     ai;
  logic [PTR_W-1:0] ptr;
  logic     ctrl_load, ptr_adv;
  logic     rd_issue;
  rd_kind_t rd_kind;
  logic     err_set;
  logic     first_rd;
  logic     byte_ev;
  logic     ptr_in_range;

  i2c_ptr_addr_chk #(.SEL_W(SEL_W)) u_addr (
    .addr_byte (rx_byte),
    .addr_sel  (addr_sel),
    .match     (addr_match),
    .is_read   (addr_rd)
  );

  i2c_ptr_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .load      (ctrl_load),
    .load_byte (rx_byte),
    .adv       (ptr_adv),
    .ai        (ai),
    .ptr       (ptr)
  );

  i2c_ptr_rdpath u_rd (
    .clk        (clk),
    .rst        (rst),
    .issue      (rd_issue),
    .issue_kind (rd_kind),
    .issue_idx  (ptr),
    .rf_rdata   (rf_rdata),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte)
  );

  assign byte_ev      = rx_valid && !ev_start && !ev_stop;
  assign ptr_in_range = (ptr <= LAST_IDX);

  always_comb begin
    state_n   = state;
    ctrl_load = 1'b0;
    ptr_adv   = 1'b0;
    rd_issue  = 1'b0;
    rd_kind   = RK_REG;
    err_set   = 1'b0;
    if (ev_start) begin
      state_n = ST_ADDR;
    end else if (ev_stop) begin
      state_n = ST_IDLE;
    end else if (rx_valid) begin
      unique case (state)
        ST_ADDR: begin
          if (!addr_match)  state_n = ST_IGNORE;
          else if (addr_rd) state_n = ST_RDATA;
          else              state_n = ST_CTRL;
        end
        ST_CTRL: begin
          ctrl_load = 1'b1;
          state_n   = ST_WDATA;
        end
        ST_WDATA: ptr_adv = 1'b1;
        default: ;
      endcase
    end else if (tx_req && (state == ST_RDATA)) begin
      rd_issue = 1'b1;
      if (ai && first_rd && (ptr == '0)) begin
        rd_kind = RK_ERR;
        err_set = 1'b1;
      end else begin
        rd_kind = ptr_in_range ? RK_REG : RK_ZERO;
        ptr_adv = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_rd <= 1'b0;
    end else if (ev_stop) begin
      first_rd <= 1'b0;
    end else if (byte_ev && (state == ST_ADDR) && addr_match && addr_rd) begin
      first_rd <= 1'b1;
    end else if (rd_issue) begin
      first_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ai_err <= 1'b0;
    end else if (ev_stop) begin
      ai_err <= 1'b0;
    end else if (err_set) begin
      ai_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= byte_ev && ((state == ST_ADDR) || (state == ST_CTRL) ||
                               (state == ST_WDATA));
      if (byte_ev) ack <= (state == ST_ADDR) ? addr_match : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= byte_ev && (state == ST_WDATA) && ptr_in_range;
      if (byte_ev && (state == ST_WDATA)) begin
        wr_idx  <= ptr;
        wr_data <= rx_byte;
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= LAST_IDX)); // R8

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_idx <= LAST_IDX)); // R8

  AST_ERR_SENDS_FF: assert property (@(posedge clk) disable iff (rst)
    $rose(ai_err) |=> (tx_valid && (tx_byte == '1))); // R9

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(ev_stop) |-> !ai_err); // R9

  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |=> (!ack_valid && !wr_en)); // R10

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en)); // R5
endmodule

// File: tb/sim_i2c_reg_pointer.sv
`timescale 1ns/1ps
module sim_i2c_reg_pointer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr_sel = 3'b101;
  logic       ev_start = 0, ev_stop = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] rf_rdata;
  logic       ack_valid, ack, wr_en, rd_en, tx_valid, ai_err;
  logic [3:0] wr_idx, rd_idx;
  logic [7:0] wr_data, tx_byte;

  always #5 clk = ~clk;

  i2c_reg_pointer u0 (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .ev_start(ev_start),
    .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .rf_rdata(rf_rdata), .ack_valid(ack_valid), .ack(ack),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en),
    .rd_idx(rd_idx), .tx_valid(tx_valid), .tx_byte(tx_byte), .ai_err(ai_err)
  );

  // environment register file, combinational read
  logic [7:0] env_rf [10];
  assign rf_rdata = (rd_idx < 4'd10) ? env_rf[rd_idx] : 8'h00;
  always @(posedge clk) if (wr_en && wr_idx < 4'd10) env_rf[wr_idx] <= wr_data;

  // behavioural reference model
  int st, ptr, p1k, p1i;
  bit ai, first, err, p1v;
  bit e_ackv, e_ack, e_wr, e_rd, e_txv;
  int e_wi, e_wd, e_ri, e_tx;
  int mrf [10];
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  function automatic int adv_ptr(int p);
    return (p >= 9) ? 0 : p + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st = 0; ptr = 0; ai = 0; first = 0; err = 0; p1v = 0; p1k = 0; p1i = 0;
      e_ackv = 0; e_ack = 0; e_wr = 0; e_rd = 0; e_txv = 0;
      e_wi = 0; e_wd = 0; e_ri = 0; e_tx = 0;
    end else begin
      e_ackv = 0; e_wr = 0; e_rd = 0; e_txv = 0;
      if (p1v) begin
        e_txv = 1;
        e_tx = (p1k == 0) ? mrf[p1i] : ((p1k == 1) ? 0 : 255);
      end
      p1v = 0;
      if (ev_stop) err = 0;
      if (ev_start) st = 1;
      else if (ev_stop) begin st = 0; first = 0; end
      else if (rx_valid) begin
        case (st)
          1: begin
            e_ackv = 1;
            if (rx_byte[7:4] == 4'b1100 && rx_byte[3:1] == addr_sel) begin
              e_ack = 1;
              if (rx_byte[0]) begin st = 4; first = 1; end else st = 2;
            end else begin e_ack = 0; st = 5; end
          end
          2: begin e_ackv = 1; e_ack = 1; ai = rx_byte[4]; ptr = rx_byte[3:0]; st = 3; end
          3: begin
            e_ackv = 1; e_ack = 1;
            if (ptr < 10) begin e_wr = 1; e_wi = ptr; e_wd = rx_byte; mrf[ptr] = rx_byte; end
            if (ai) ptr = adv_ptr(ptr);
          end
          default: ;
        endcase
      end else if (tx_req && st == 4) begin
        if (ai && first && ptr == 0) begin p1k = 2; err = 1; end
        else begin
          if (ptr < 10) begin e_rd = 1; e_ri = ptr; p1k = 0; p1i = ptr; end
          else p1k = 1;
          if (ai) ptr = adv_ptr(ptr);
        end
        p1v = 1; first = 0;
      end
    end
  end

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      bit bad;
      bad = (ack_valid != e_ackv) || (e_ackv && ack != e_ack) ||
            (wr_en != e_wr) || (e_wr && (wr_idx != e_wi[3:0] || wr_data != e_wd[7:0])) ||
            (rd_en != e_rd) || (e_rd && rd_idx != e_ri[3:0]) ||
            (tx_valid != e_txv) || (e_txv && tx_byte != e_tx[7:0]) ||
            (ai_err != err);
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s t=%0t act ackv=%b ack=%b wr=%b/%0d/%h rd=%b/%0d tx=%b/%h err=%b exp ackv=%b ack=%b wr=%b/%0d/%h rd=%b/%0d tx=%b/%h err=%b",
          cur_req, $time, ack_valid, ack, wr_en, wr_idx, wr_data, rd_en, rd_idx,
          tx_valid, tx_byte, ai_err, e_ackv, e_ack, e_wr, e_wi, e_wd[7:0], e_rd, e_ri,
          e_txv, e_tx[7:0], err);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start();
    @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; idle(2);
  endtask
  task automatic do_stop();
    @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0; idle(2);
  endtask
  task automatic send(logic [7:0] b);
    @(negedge clk) begin rx_valid = 1; rx_byte = b; end
    @(negedge clk) rx_valid = 0; idle(3);
  endtask
  task automatic fetch();
    @(negedge clk) tx_req = 1; @(negedge clk) tx_req = 0; idle(4);
  endtask

  localparam logic [7:0] AW = 8'hCA, AR = 8'hCB;
  bit done = 0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 10; i++) begin env_rf[i] = 8'h00; mrf[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; idle(4);
    // R2, R3, R4: write transfer, upper control bits written as ones
    cur_req = "R2"; do_start(); send(AW);
    cur_req = "R4"; send(8'hE2);
    cur_req = "R5"; send(8'h11); send(8'h22);   // no AI: both to index 2 (R6)
    do_stop();
    // R6/R7: AI from 7 across the wrap
    cur_req = "R7"; do_start(); send(AW); send(8'h17);
    send(8'hA7); send(8'hA8); send(8'hA9); send(8'hA0);
    do_stop();
    // R11/R12/R3: read continues at retained pointer 1
    cur_req = "R11"; do_start(); send(AR);
    cur_req = "R12"; fetch(); fetch(); fetch();
    cur_req = "R11"; do_start(); send(AR); fetch();
    do_stop();
    // R8: unimplemented indices
    cur_req = "R8"; do_start(); send(AW); send(8'h1C); send(8'h55); send(8'h66);
    do_start(); send(AW); send(8'h0B);
    do_start(); send(AR); fetch(); fetch();
    do_start(); send(AW); send(8'h1F); send(8'h77); send(8'h88);
    do_stop();
    // R9: AI read starting at 0
    cur_req = "R9"; do_start(); send(AW); send(8'h10); do_stop();
    do_start(); send(AR); fetch(); fetch(); fetch();
    do_stop(); idle(2);
    // R6: AI read, no error when starting at 5
    cur_req = "R6"; do_start(); send(AW); send(8'h15); do_start(); send(AR);
    fetch(); fetch(); do_stop();
    // R10: mismatch, then ignored bytes
    cur_req = "R10"; do_start(); send(8'hC2); send(8'h03); send(8'h99); fetch();
    do_start(); send(8'h4A); send(8'h01); send(8'h42);
    cur_req = "R2"; do_start(); send(AW); send(8'h03); send(8'h5A); do_stop();
    cur_req = "R3"; do_start(); send(AR); fetch(); do_stop();
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule